// File: doc/BRIEF.md
# Receive Descriptor Ring Fill Controller

This block is the device-side manager of one receive descriptor ring that lives in host memory. The host hands empty buffers to the device by moving a write index forward. Each arriving frame takes the descriptor at the device's read index. While the frame fills that buffer, the buffer is "open". The buffer closes in one of two ways: the frame source signals the end of the frame, or a coarse close timer runs out. When it closes, the block publishes the index of that descriptor on a 12-bit status output with a one-cycle update strobe. It can also raise an interrupt pulse.

One configuration word selects several settings. It sets the run mode: halt at once, pause after the current frame, or run. It also sets the ring size as a power of two, the buffer size, the interrupt routing and the close timeout. The timeout is counted in periods of an external prescaled tick, one tick every 32 µs. A plain idle output tells the host when the channel has stopped after it was disabled. Moving descriptors and frame payload on the bus is handled elsewhere.

Frame arrival uses a valid/ready handshake. The source raises `frm_valid` and must hold it until it sees `frm_ready` high on a rising edge. A frame is accepted only on a cycle where both are high. The block holds `frm_ready` low whenever it cannot take a buffer, and this is its only form of back-pressure. `frm_end` is a plain one-cycle pulse.

Top module: `ring_fill_ctrl`

## Requirements
- R1: `buf_len_4k` reports config bits 17:16 plus one: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4, in units of 4 KiB.
- R2: `frm_ready` is high only when config bits 31:30 equal 10, no buffer is open, and a free descriptor exists. An accepted frame opens the descriptor at the read index, and the read index then steps by one modulo the ring size.
- R3: Config bits 23:20 give the ring exponent N, limited to the range 5..12. The ring holds 2^N entries. All index comparisons are taken modulo 2^N, so write-index bits at or above N have no effect.
- R4: The three low bits of the written write index are ignored. The host index counts only in steps of 8.
- R5: When the read index equals the aligned write index modulo the ring size, no descriptor is free and `frm_ready` stays low. At most 2^N−1 buffers can therefore be filled before the host moves the write index again.
- R6: A `frm_end` pulse while a buffer is open closes that buffer. On the next rising edge `stat_upd` pulses for one cycle and `stat_idx` takes the closed descriptor's index. `stat_idx` changes at no other time.
- R7: `irq` pulses together with `stat_upd` only when config bits 13:12 equal 01. With any other value there is no interrupt.
- R8: Config bits 11:4 hold a timeout T. When T is not zero, the buffer closes as in R6 on the edge that samples the T-th `tick` after the frame was accepted. The count starts again from zero at each accepted frame. When T is zero, the timer never closes a buffer.
- R9: Mode 01 accepts no new frame but lets an open buffer finish through `frm_end`. The channel is idle from that close onward.
- R10: Modes 00 and 11 accept no new frame. They discard an open buffer on the first edge after the mode takes effect, with no status update. The discarded descriptor stays consumed.
- R11: `ch_idle` is high exactly when the mode is not 10 and no buffer is open. After reset, `ch_idle` is 1, `frm_ready` is 0, `stat_idx` is 0, and `stat_upd` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| widx_we | input | 1 | Write strobe for the host write index |
| widx_wdata | input | IDX_W | Host write index |
| tick | input | 1 | Prescaled timeout tick, one cycle per 32 µs |
| frm_valid | input | 1 | A frame is waiting for a buffer |
| frm_ready | output | 1 | The block can accept a frame |
| frm_end | input | 1 | The frame in the open buffer has completed |
| stat_idx | output | IDX_W | Index of the most recently closed descriptor |
| stat_upd | output | 1 | One-cycle strobe when `stat_idx` is published |
| irq | output | 1 | One-cycle interrupt pulse to the host |
| ch_idle | output | 1 | Channel is disabled and holds no open buffer |
| buf_len_4k | output | 3 | Configured buffer size in 4 KiB units |

## Verification
The fill path is run with a table of ring exponents and host write indices. The table includes a normal 32-entry ring and larger rings, exponents below and above the allowed range, write indices with their low three bits set, and indices whose high bits lie outside the ring. Each entry counts how many frames are accepted before `frm_ready` drops and checks the last published index. This separates the modulo wrap, the exponent limits, the alignment masking and the rule that an equal read and write index means the ring is empty. Directed runs then cover three things. The first is close by timeout, with and without a restart, against close by frame end. The second is how each of the three disable modes handles an open buffer. The third is the interrupt routing values.

// File: rtl/ring_fill_pkg.sv
package ring_fill_pkg;

  typedef enum logic [1:0] {
    MODE_HALT  = 2'b00,
    MODE_DRAIN = 2'b01,
    MODE_RUN   = 2'b10,
    MODE_RSVD  = 2'b11
  } fill_mode_e;

  typedef enum logic [1:0] {
    DEST_NONE = 2'b00,
    DEST_HOST = 2'b01,
    DEST_RSV2 = 2'b10,
    DEST_RSV3 = 2'b11
  } irq_dest_e;

  // Field widths follow the configuration word layout.
  localparam int unsigned TMO_W = 8;

  typedef struct packed {
    fill_mode_e       mode;
    logic [3:0]       ring_log2;
    logic [1:0]       buf_sel;
    irq_dest_e        dest;
    logic [TMO_W-1:0] tmo;
  } fill_cfg_t;

endpackage

// File: rtl/ring_fill_cfg.sv
module ring_fill_cfg
  import ring_fill_pkg::*;
#(
  parameter int unsigned IDX_W    = 12,
  parameter int unsigned LOG2_W   = 4,
  parameter int unsigned LOG2_MIN = 5,
  parameter int unsigned LOG2_MAX = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              widx_we,
  input  logic [IDX_W-1:0]  widx_wdata,
  output fill_cfg_t         cfg,
  output logic [LOG2_W-1:0] ring_log2,
  output logic [IDX_W-1:0]  widx,
  output logic [2:0]        buf_len_4k
);

  localparam logic [LOG2_W-1:0] L2_LO = LOG2_W'(LOG2_MIN);
  localparam logic [LOG2_W-1:0] L2_HI = LOG2_W'(LOG2_MAX);

  fill_cfg_t          cfg_q;
  logic [IDX_W-1:0]   widx_q;
  logic [LOG2_W-1:0]  l2_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mode: MODE_HALT, ring_log2: '0, buf_sel: '0,
                  dest: DEST_NONE, tmo: '0};
      widx_q <= '0;
    end else begin
      if (cfg_we) begin
        cfg_q <= '{mode:      fill_mode_e'(cfg_wdata[31:30]),
                   ring_log2: cfg_wdata[23:20],
                   buf_sel:   cfg_wdata[17:16],
                   dest:      irq_dest_e'(cfg_wdata[13:12]),
                   tmo:       cfg_wdata[11:4]};
      end
      if (widx_we) widx_q <= widx_wdata;
    end
  end

  assign l2_raw = LOG2_W'(cfg_q.ring_log2);

  always_comb begin
    if (l2_raw < L2_LO)      ring_log2 = L2_LO;
    else if (l2_raw > L2_HI) ring_log2 = L2_HI;
    else                     ring_log2 = l2_raw;
  end

  assign cfg        = cfg_q;
  assign widx       = widx_q;
  assign buf_len_4k = {1'b0, cfg_q.buf_sel} + 3'd1;

endmodule

// File: rtl/ring_fill_ptr.sv
module ring_fill_ptr #(
  parameter int unsigned IDX_W      = 12,
  parameter int unsigned LOG2_W     = 4,
  parameter int unsigned ALIGN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LOG2_W-1:0] ring_log2,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              has_free
);

  localparam logic [IDX_W-1:0] ALIGN_MASK =
    ~((IDX_W'(1) << ALIGN_LOG2) - IDX_W'(1));

  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] wr_al;
  logic [IDX_W-1:0] gap;
  logic [IDX_W-1:0] rd_q;

  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign mask[i] = (LOG2_W'(i) < ring_log2);
  end

  assign wr_al    = widx & ALIGN_MASK;
  assign gap      = (wr_al - rd_q) & mask;
  assign has_free = |gap;
  assign rd_idx   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_q <= '0;
    else if (take) rd_q <= (rd_q + IDX_W'(1)) & mask;
  end

  // R5: a descriptor is only taken when the ring has a free one.
  p_take_needs_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_free);

endmodule

// File: rtl/ring_fill_timer.sv
module ring_fill_timer #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             hit
);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + TMO_W'(1);
  assign hit    = active && tick && (limit != '0) && (cnt_nx == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start)            cnt_q <= '0;
    else if (active && tick)   cnt_q <= cnt_nx;
  end

  // R8: with a zero limit the timer never closes a buffer.
  p_zero_limit_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !hit);

endmodule

// File: rtl/ring_fill_ctrl.sv
module ring_fill_ctrl
  import ring_fill_pkg::*;
#(
  parameter int unsigned IDX_W      = 12,
  parameter int unsigned LOG2_MIN   = 5,
  parameter int unsigned LOG2_MAX   = 12,
  parameter int unsigned ALIGN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             widx_we,
  input  logic [IDX_W-1:0] widx_wdata,
  input  logic             tick,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic             frm_end,
  output logic [IDX_W-1:0] stat_idx,
  output logic             stat_upd,
  output logic             irq,
  output logic             ch_idle,
  output logic [2:0]       buf_len_4k
);

  localparam int unsigned LOG2_W = $clog2(LOG2_MAX + 1);

  fill_cfg_t         cfg;
  logic [LOG2_W-1:0] ring_log2;
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  rd_idx;
  logic              has_free;
  logic              tmo_hit;

  logic              open_q;
  logic [IDX_W-1:0]  open_idx_q;
  logic [IDX_W-1:0]  stat_idx_q;
  logic              stat_upd_q;
  logic              irq_q;

  logic              run_mode;
  logic              halt_mode;
  logic              take;
  logic              close;

  ring_fill_cfg #(
    .IDX_W(IDX_W), .LOG2_W(LOG2_W), .LOG2_MIN(LOG2_MIN), .LOG2_MAX(LOG2_MAX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .widx_we(widx_we), .widx_wdata(widx_wdata),
    .cfg(cfg), .ring_log2(ring_log2), .widx(widx), .buf_len_4k(buf_len_4k)
  );

  ring_fill_ptr #(
    .IDX_W(IDX_W), .LOG2_W(LOG2_W), .ALIGN_LOG2(ALIGN_LOG2)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .take(take), .widx(widx),
    .ring_log2(ring_log2), .rd_idx(rd_idx), .has_free(has_free)
  );

  ring_fill_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(take), .active(open_q),
    .tick(tick), .limit(cfg.tmo), .hit(tmo_hit)
  );

  assign run_mode  = (cfg.mode == MODE_RUN);
  assign halt_mode = (cfg.mode == MODE_HALT) || (cfg.mode == MODE_RSVD);
  assign frm_ready = run_mode && !open_q && has_free;
  assign take      = frm_valid && frm_ready;
  assign close     = open_q && !halt_mode && (frm_end || tmo_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      open_idx_q <= '0;
      stat_idx_q <= '0;
      stat_upd_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (take) begin
        open_q     <= 1'b1;
        open_idx_q <= rd_idx;
      end else if (close || (open_q && halt_mode)) begin
        open_q     <= 1'b0;
      end
      stat_upd_q <= close;
      irq_q      <= close && (cfg.dest == DEST_HOST);
      if (close) stat_idx_q <= open_idx_q;
    end
  end

  assign stat_idx = stat_idx_q;
  assign stat_upd = stat_upd_q;
  assign irq      = irq_q;
  assign ch_idle  = !run_mode && !open_q;

  p_single_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> !frm_ready);

  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_upd |-> $stable(stat_idx));

  p_upd_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |=> !stat_upd);

  p_irq_needs_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_upd);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_idle && $past(ch_idle)) |-> !stat_upd);

  p_idle_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_idle |-> !frm_ready);

endmodule

// File: tb/ring_fill_ctrl_tb_top.sv
module ring_fill_ctrl_tb_top;

  localparam int IDX_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic             widx_we = 1'b0;
  logic [IDX_W-1:0] widx_wdata = '0;
  logic             tick = 1'b0;
  logic             frm_valid = 1'b0;
  logic             frm_ready;
  logic             frm_end = 1'b0;
  logic [IDX_W-1:0] stat_idx;
  logic             stat_upd;
  logic             irq;
  logic             ch_idle;
  logic [2:0]       buf_len_4k;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ring_fill_ctrl #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .widx_we(widx_we), .widx_wdata(widx_wdata), .tick(tick),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_end(frm_end),
    .stat_idx(stat_idx), .stat_upd(stat_upd), .irq(irq),
    .ch_idle(ch_idle), .buf_len_4k(buf_len_4k)
  );

  // {ring exponent[31:28], write index[27:16], expected frames[15:8], pad}
  localparam logic [31:0] VEC [0:7] = '{
    32'h5_008_08_00, 32'h5_010_10_00, 32'h5_02F_08_00, 32'h5_007_00_00,
    32'h3_018_18_00, 32'h6_028_28_00, 32'hF_020_20_00, 32'h5_1F8_18_00
  };

  function automatic logic [31:0] cw(input logic [1:0] mode, input logic [3:0] l2,
                                     input logic [1:0] bsz, input logic [1:0] dest,
                                     input logic [7:0] tmo);
    return {mode, 6'd0, l2, 2'd0, bsz, 2'd0, dest, tmo, 4'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
  endtask

  task automatic put_cfg(input logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w; cyc(); cfg_we = 1'b0;
  endtask

  task automatic put_widx(input logic [IDX_W-1:0] w);
    widx_we = 1'b1; widx_wdata = w; cyc(); widx_we = 1'b0;
  endtask

  task automatic accept();
    frm_valid = 1'b1; cyc(); frm_valid = 1'b0;
  endtask

  task automatic finish_frame();
    frm_end = 1'b1; cyc(); frm_end = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 idle", 32'(ch_idle), 1);
    check("R11 ready", 32'(frm_ready), 0);
    check("R11 stat_idx", 32'(stat_idx), 0);
    check("R11 stat_upd", 32'(stat_upd), 0);
    check("R11 irq", 32'(irq), 0);

    // R2: halted channel refuses frames even with free descriptors
    put_widx(12'h008);
    check("R2 halt ready", 32'(frm_ready), 0);

    // Table: fill count per ring size and write index (R3 R4 R5 R6)
    for (int v = 0; v < 8; v++) begin
      int got;
      logic [IDX_W-1:0] last;
      got = 0; last = '0;
      do_reset();
      put_cfg(cw(2'b10, VEC[v][31:28], 2'b00, 2'b01, 8'd0));
      put_widx(VEC[v][27:16]);
      for (int k = 0; k < 70; k++) begin
        if (!frm_ready) break;
        accept();
        finish_frame();
        if (stat_upd !== 1'b1 || stat_idx !== IDX_W'(got)) begin
          check("R6 publish", {19'd0, stat_upd, stat_idx}, {20'h00001, IDX_W'(got)});
        end
        last = stat_idx;
        got++;
      end
      check("R3 R4 R5 frames filled", 32'(got), 32'(VEC[v][15:8]));
      if (VEC[v][15:8] != 0) check("R6 last index", 32'(last), 32'(VEC[v][15:8]) - 1);
    end

    // R1 buffer size decode
    for (int b = 0; b < 4; b++) begin
      put_cfg(cw(2'b10, 4'd5, 2'(b), 2'b01, 8'd0));
      cyc();
      check("R1 buf_len", 32'(buf_len_4k), 32'(b + 1));
    end

    // R7 interrupt routing
    do_reset();
    put_widx(12'h008);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b00, 8'd0));
    accept(); finish_frame();
    check("R7 dest00 upd", 32'(stat_upd), 1);
    check("R7 dest00 irq", 32'(irq), 0);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b10, 8'd0));
    accept(); finish_frame();
    check("R7 dest10 irq", 32'(irq), 0);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    accept(); finish_frame();
    check("R7 dest01 irq", 32'(irq), 1);
    check("R6 idx after three", 32'(stat_idx), 2);

    // R8 timeout close and restart
    do_reset();
    put_widx(12'h008);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b01, 8'd3));
    accept();
    for (int t = 1; t <= 3; t++) begin
      pulse_tick();
      check("R8 tmo upd", 32'(stat_upd), (t == 3) ? 1 : 0);
      if (t == 3) check("R8 tmo irq", 32'(irq), 1);
      cyc();
    end
    accept();
    cyc(); cyc();
    for (int t = 1; t <= 3; t++) begin
      pulse_tick();
      check("R8 restart upd", 32'(stat_upd), (t == 3) ? 1 : 0);
      cyc();
    end
    check("R8 restart idx", 32'(stat_idx), 1);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    accept();
    for (int t = 0; t < 5; t++) begin
      pulse_tick();
      check("R8 zero timeout", 32'(stat_upd), 0);
    end
    finish_frame();
    check("R8 end after ticks", 32'(stat_idx), 2);

    // R9 pause at end of frame
    do_reset();
    put_widx(12'h008);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    accept();
    put_cfg(cw(2'b01, 4'd5, 2'b00, 2'b01, 8'd0));
    check("R9 ready", 32'(frm_ready), 0);
    check("R9 not idle", 32'(ch_idle), 0);
    cyc();
    check("R9 still open", 32'(ch_idle), 0);
    finish_frame();
    check("R9 upd", 32'(stat_upd), 1);
    check("R9 idle", 32'(ch_idle), 1);

    // R10 immediate halt discards open buffer
    do_reset();
    put_widx(12'h008);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    accept();
    put_cfg(cw(2'b00, 4'd5, 2'b00, 2'b01, 8'd0));
    cyc();
    check("R10 idle", 32'(ch_idle), 1);
    finish_frame();
    check("R10 no upd", 32'(stat_upd), 0);
    put_cfg(cw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    check("R10 ready again", 32'(frm_ready), 1);
    accept(); finish_frame();
    check("R10 descriptor consumed", 32'(stat_idx), 1);
    put_cfg(cw(2'b11, 4'd5, 2'b00, 2'b01, 8'd0));
    check("R10 mode11 idle", 32'(ch_idle), 1);
    check("R11 idle no ready", 32'(frm_ready), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule